// File: doc/BRIEF.md
# Ultra DMA Data-Out Burst Receiver

This block sits on the device side of a parallel disk interface. It takes in the data-out phase of an Ultra DMA burst. The host places a 16-bit word on the data lines and toggles its strobe. Every transition of the strobe, rising or falling, carries one word. The strobe and data arrive with no relation to the device clock. The block samples both through matched synchroniser chains, finds transitions by comparing successive strobe samples, and writes the word that matches each transition into a small FIFO. A local consumer empties the FIFO with a read-enable.

The block throttles the host with an active-high ready output. Ready drops when only a few FIFO slots remain, which leaves room for words the host already has in flight. The host may pause at any time by not toggling the strobe, and no timeout applies. When the host raises its stop request, the block leaves the burst. It still accepts words that arrive late. Once the strobe has been quiet for a set number of cycles, it gives a one-cycle done pulse and returns to idle. A word that arrives while the FIFO is full is discarded and sets a sticky overflow flag.

Top module: `udma_out_rx`

## Requirements
- R1: During a burst, each rising and each falling transition of `hstrobe` stores exactly one 16-bit `hdata` word. Words leave on `rd_data` in arrival order. `rd_valid` is high while the FIFO holds at least one word, and a word is consumed on a cycle where `rd_en` and `rd_valid` are both high.
- R2: A burst has no timeout. After any gap without strobe transitions, the next transitions are captured with no word lost or repeated.
- R3: `ddmardy` is high only while a burst is active and not stopping, and only while the FIFO has more than `READY_SLACK` (default 4) free slots. Otherwise it is low. It rises the cycle after `burst_en` is sampled high in idle.
- R4: A strobe transition that arrives while the FIFO holds `FIFO_DEPTH` words does not store its word and sets `overflow`. `overflow` stays high until reset.
- R5: A synchronised high on `hstop` during an active burst moves the block to a stopping phase, and `ddmardy` goes low. When no strobe transition has been seen for `QUIET_CYCLES` consecutive cycles, `burst_done` is high for exactly one cycle and `busy` goes low in that same cycle.
- R6: Strobe transitions while idle store nothing. The strobe level present when a burst starts does not count as a transition.
- R7: After reset, `busy`, `ddmardy`, `rd_valid`, `burst_done` and `overflow` are all low.
- R8: A strobe transition during the stopping phase is still stored, and it restarts the quiet count.
- R9: `hstop` while idle has no effect. `busy` and `burst_done` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_en | input | 1 | Start a data-out burst, sampled in idle |
| hstrobe | input | 1 | Host data strobe, asynchronous |
| hdata | input | 16 | Host data word, asynchronous |
| hstop | input | 1 | Host stop request, asynchronous |
| rd_en | input | 1 | Consumer read-enable |
| ddmardy | output | 1 | Device ready to take more words (active high) |
| rd_data | output | 16 | Oldest stored word |
| rd_valid | output | 1 | FIFO is not empty |
| busy | output | 1 | Burst active or stopping |
| burst_done | output | 1 | One-cycle pulse at the end of a burst |
| overflow | output | 1 | Sticky flag for a word dropped on a full FIFO |

## Verification
The properties assume that every strobe level is held for at least two clock cycles, and that the data lines change together with the strobe and then stay put until the next transition. Without this, synchronised sampling could miss an edge or pair a word with the wrong transition. The stimulus changes data and strobe on the same falling clock edge and then holds both for three cycles. It drives the consumer only from the falling edge. The stop request stays high until the done pulse has been observed.

// File: rtl/udma_rx_pkg.sv
package udma_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE     = 2'd0,
        RX_ACTIVE   = 2'd1,
        RX_STOPPING = 2'd2
    } rx_state_e;
endpackage

// File: rtl/udma_rx_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
module udma_rx_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q_out = pipe_q[STAGES-1];
endmodule

// File: rtl/udma_rx_fifo.sv
// Count-based circular FIFO; push on full and pop on empty are ignored.
module udma_rx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t   f_d, f_q;
    logic [W-1:0] mem [DEPTH];
    logic       do_push, do_pop;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d     = f_q;
        do_push = push && (f_q.cnt != CW'(DEPTH));
        do_pop  = pop && (f_q.cnt != '0);
        if (do_push) f_d.wr = wrap_inc(f_q.wr);
        if (do_pop)  f_d.rd = wrap_inc(f_q.rd);
        f_d.cnt = f_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[f_q.wr] <= wdata;
    end

    assign rdata = mem[f_q.rd];
    assign count = f_q.cnt;
endmodule

// File: rtl/udma_rx_ctrl.sv
// Burst sequencing, edge detection, flow control and overflow tracking.
module udma_rx_ctrl
    import udma_rx_pkg::*;
#(
    parameter int W      = 16,
    parameter int DEPTH  = 16,
    parameter int SLACK  = 4,
    parameter int QUIET  = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int QW    = $clog2(QUIET + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst_en,
    input  logic          stb,
    input  logic [W-1:0]  dat,
    input  logic          stop,
    input  logic          pop,
    input  logic [CW-1:0] fifo_cnt,
    output logic          push,
    output logic [W-1:0]  push_data,
    output logic          ready,
    output logic          done,
    output logic          overflow,
    output logic          busy
);
    typedef struct packed {
        rx_state_e     state;
        logic          stb_prev;
        logic [QW-1:0] quiet;
        logic          ready;
        logic          done;
        logic          ovf;
    } ctrl_st_t;

    ctrl_st_t      r_d, r_q;
    logic          edge_seen, capture, full, pop_ok;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.stb_prev = stb;
        edge_seen    = stb ^ r_q.stb_prev;
        full         = (fifo_cnt == CW'(DEPTH));
        capture      = edge_seen && (r_q.state != RX_IDLE);
        push         = capture && !full;
        push_data    = dat;
        if (capture && full) r_d.ovf = 1'b1;

        unique case (r_q.state)
            RX_IDLE: begin
                if (burst_en) r_d.state = RX_ACTIVE;
            end
            RX_ACTIVE: begin
                if (stop) begin
                    r_d.state = RX_STOPPING;
                    r_d.quiet = '0;
                end
            end
            RX_STOPPING: begin
                if (edge_seen) begin
                    r_d.quiet = '0;
                end else if (r_q.quiet == QW'(QUIET - 1)) begin
                    r_d.state = RX_IDLE;
                    r_d.quiet = '0;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.quiet = r_q.quiet + 1'b1;
                end
            end
            default: r_d.state = RX_IDLE;
        endcase

        pop_ok    = pop && (fifo_cnt != '0);
        cnt_nx    = fifo_cnt + CW'(push) - CW'(pop_ok);
        r_d.ready = (r_d.state == RX_ACTIVE) &&
                    ((CW'(DEPTH) - cnt_nx) > CW'(SLACK));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: RX_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign ready    = r_q.ready;
    assign done     = r_q.done;
    assign overflow = r_q.ovf;
    assign busy     = (r_q.state != RX_IDLE);
endmodule

// File: rtl/udma_out_rx.sv
module udma_out_rx #(
    parameter int DATA_W       = 16,
    parameter int FIFO_DEPTH   = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int READY_SLACK  = 4,
    parameter int QUIET_CYCLES = 8,
    localparam int CNT_W       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_en,
    input  logic              hstrobe,
    input  logic [DATA_W-1:0] hdata,
    input  logic              hstop,
    input  logic              rd_en,
    output logic              ddmardy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              burst_done,
    output logic              overflow
);
    logic [DATA_W:0]   bus_sync;
    logic              stop_sync;
    logic              push;
    logic [DATA_W-1:0] push_data;
    logic [CNT_W-1:0]  fifo_cnt;

    // Strobe and data share one chain so each word stays aligned with its edge.
    udma_rx_sync #(.W(DATA_W + 1), .STAGES(SYNC_STAGES)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d_in({hstrobe, hdata}), .q_out(bus_sync)
    );

    udma_rx_sync #(.W(1), .STAGES(SYNC_STAGES)) u_stop_sync (
        .clk(clk), .rst_n(rst_n), .d_in(hstop), .q_out(stop_sync)
    );

    udma_rx_ctrl #(
        .W(DATA_W), .DEPTH(FIFO_DEPTH), .SLACK(READY_SLACK), .QUIET(QUIET_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .burst_en(burst_en),
        .stb(bus_sync[DATA_W]), .dat(bus_sync[DATA_W-1:0]),
        .stop(stop_sync), .pop(rd_en), .fifo_cnt(fifo_cnt),
        .push(push), .push_data(push_data), .ready(ddmardy),
        .done(burst_done), .overflow(overflow), .busy(busy)
    );

    udma_rx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_data),
        .pop(rd_en), .rdata(rd_data), .count(fifo_cnt)
    );

    assign rd_valid = (fifo_cnt != '0);
endmodule

// File: rtl/udma_out_rx_chk.sv
module udma_out_rx_chk #(
    parameter int DEPTH = 16,
    parameter int SLACK = 4,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ddmardy,
    input logic          busy,
    input logic          burst_done,
    input logic          overflow,
    input logic [CW-1:0] fifo_cnt
);
    p_ready_in_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ddmardy |-> busy);

    p_ready_slack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ddmardy |-> (int'(fifo_cnt) < DEPTH - SLACK));

    p_overflow_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_cnt) <= DEPTH);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> !busy);
endmodule

bind udma_out_rx udma_out_rx_chk #(
    .DEPTH(FIFO_DEPTH), .SLACK(READY_SLACK), .CW(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ddmardy(ddmardy), .busy(busy),
    .burst_done(burst_done), .overflow(overflow), .fifo_cnt(fifo_cnt)
);

// File: tb/sim_udma_out_rx.sv
`timescale 1ns/1ps
module sim_udma_out_rx;
    localparam int DEPTH = 16;
    localparam int SLACK = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        burst_en = 1'b0;
    logic        hstrobe = 1'b0;
    logic [15:0] hdata = '0;
    logic        hstop = 1'b0;
    logic        rd_en = 1'b0;
    logic        ddmardy, rd_valid, busy, burst_done, overflow;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] exp_q[$];

    always #2.5 clk = ~clk;

    udma_out_rx u0 (
        .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .hstrobe(hstrobe),
        .hdata(hdata), .hstop(hstop), .rd_en(rd_en), .ddmardy(ddmardy),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
        .burst_done(burst_done), .overflow(overflow)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one strobe transition with a word; records it if it should be stored.
    task automatic send_word(input logic [15:0] d, input logic keep);
        hdata   = d;
        hstrobe = ~hstrobe;
        if (keep) exp_q.push_back(d);
        repeat (3) @(negedge clk);
    endtask

    task automatic count_done(input int cycles, output int pulses);
        pulses = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (burst_done) pulses++;
        end
    endtask

    // Monitor: compares every consumed word against the scoreboard (R1).
    always @(negedge clk) begin
        if (rst_n && rd_en && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected word", int'(rd_data), 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R1 word order", int'(rd_data), int'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int pulses;
        repeat (3) @(negedge clk);
        // R7 reset state
        check(!busy && !ddmardy && !rd_valid && !burst_done && !overflow,
              "R7 reset outputs", {busy, ddmardy, rd_valid, burst_done, overflow}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 idle transitions are ignored
        send_word(16'hDEAD, 1'b0);
        send_word(16'hBEEF, 1'b0);
        send_word(16'h0BAD, 1'b0);
        repeat (4) @(negedge clk);
        check(!rd_valid, "R6 idle edge stored", rd_valid, 0);

        burst_en = 1'b1;
        repeat (2) @(negedge clk);
        burst_en = 1'b0;
        check(busy && ddmardy, "R3 ready at burst start", {busy, ddmardy}, 3);
        repeat (4) @(negedge clk);
        check(!rd_valid, "R6 entry level counted as edge", rd_valid, 0);

        // R1 both edges, varied patterns; R2 long pause
        rd_en = 1'b1;
        for (int i = 0; i < 10; i++) send_word(16'h1111 * i[15:0] ^ 16'hA5A5, 1'b1);
        repeat (500) @(negedge clk);
        check(busy && ddmardy, "R2 still active after pause", {busy, ddmardy}, 3);
        send_word(16'h0000, 1'b1);
        send_word(16'hFFFF, 1'b1);
        send_word(16'h8001, 1'b1);
        send_word(16'h7FFE, 1'b1);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R2 all words after pause", exp_q.size(), 0);

        // R3 threshold while filling, R4 overflow
        rd_en = 1'b0;
        @(negedge clk);
        for (int k = 1; k <= DEPTH; k++) begin
            send_word(16'h4000 + k[15:0], 1'b1);
            repeat (1) @(negedge clk);
            check(ddmardy == ((DEPTH - k) > SLACK), "R3 ready vs free slots",
                  ddmardy, int'((DEPTH - k) > SLACK));
        end
        check(!overflow, "R4 no overflow at exactly full", overflow, 0);
        send_word(16'hEEEE, 1'b0);
        repeat (2) @(negedge clk);
        check(overflow, "R4 overflow set", overflow, 1);
        rd_en = 1'b1;
        repeat (DEPTH + 4) @(negedge clk);
        check(!rd_valid && exp_q.size() == 0, "R4 dropped word absent",
              exp_q.size(), 0);
        check(overflow, "R4 overflow sticky", overflow, 1);
        check(ddmardy, "R3 ready back after drain", ddmardy, 1);

        // R5 stop, R8 late word
        hstop = 1'b1;
        repeat (4) @(negedge clk);
        check(!ddmardy && busy, "R5 ready drops on stop", {busy, ddmardy}, 2);
        send_word(16'hC0DE, 1'b1);
        count_done(40, pulses);
        check(pulses == 1, "R5 single done pulse", pulses, 1);
        check(!busy, "R5 idle after done", busy, 0);
        check(exp_q.size() == 0, "R8 late word captured", exp_q.size(), 0);
        hstop = 1'b0;
        repeat (4) @(negedge clk);

        // R9 stop while idle
        hstop = 1'b1;
        count_done(20, pulses);
        hstop = 1'b0;
        check(pulses == 0 && !busy, "R9 idle stop ignored", pulses, 0);
        repeat (4) @(negedge clk);

        // second burst works after the first
        burst_en = 1'b1;
        repeat (2) @(negedge clk);
        burst_en = 1'b0;
        for (int i = 0; i < 4; i++) send_word(16'h3C00 | i[15:0], 1'b1);
        check(ddmardy, "R3 ready in second burst", ddmardy, 1);
        hstop = 1'b1;
        count_done(40, pulses);
        hstop = 1'b0;
        check(pulses == 1 && !busy, "R5 second burst done", pulses, 1);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R1 scoreboard empty", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule